// File: doc/BRIEF.md
# Status-Tagged Receive Character Queue

This block sits behind the deserializer of an asynchronous serial receiver. Each time the shift stage finishes a character it presents the character together with three per-character status indications (parity fault, framing fault, line break). The block stores character and status together in a 32-entry first-in first-out queue, so a fault always travels with the character that caused it. The host pops the oldest entry with a read strobe and sees a 16-bit word holding the character, its fault bits, a summary fault bit and a valid bit.

The block also produces the level flags the host uses to decide when to service the queue. A programmable fill threshold drives a receiver-ready flag. A data-ready flag is raised whenever anything is stored. Two sticky flags record an overrun and a detected break, and each is cleared by a write-one-to-clear strobe. The incoming character stream is valid-only and has no back-pressure: the shift stage cannot be stalled, so a character that finds the queue full is discarded and recorded as an overrun. The read side is a plain strobe. A word is removed only when `rd_req` is high at a rising edge while the queue holds data. Pulling `rx_enable` low flushes the queue and the sticky flags.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: `rd_word` shows the oldest stored entry. Bit 15 is 1 (valid). Bit 14 is the OR of bits 13..10. Bit 13 is overrun, bit 12 is framing fault, bit 11 is break and bit 10 is parity fault. Bits 9..8 are 0 and bits 7..0 hold the character. When the queue is empty, the whole word is 0.
- R2: Up to 32 characters are held and returned in arrival order. `fifo_full` is 1 exactly when 32 are held and `fifo_empty` is 1 exactly when none are held. A push and a pop in the same cycle both take effect.
- R3: `rx_rdy` is 1 when the number of stored characters is at least the 6-bit trigger level. The trigger level is loaded from `cfg_level` when `cfg_wr` is high and resets to 1.
- R4: `data_rdy` is 1 whenever at least one character is stored, whatever the trigger level.
- R5: `brk_flag` is set by any character that arrives with `in_brk` high while the block is enabled. It stays set until it is cleared through `clr_w1c[1]`. A set in the same cycle wins over the clear.
- R6: A character that arrives while the queue is full at that edge is discarded, even if a read happens in the same cycle. `ovr_flag` is set, and bit 13 of the newest stored entry is set.
- R7: A read strobe while the queue is empty changes nothing. The next character stored is the next one read.
- R8: `ovr_flag` is sticky and is cleared by a one on `clr_w1c[0]`. A clear of one flag leaves the other flag unchanged.
- R9: While `rx_enable` is low, the queue is emptied and both sticky flags are cleared at the next edge. Arriving characters and reads are ignored during that time. The trigger level is kept.
- R10: After reset the queue is empty, `rx_rdy`, `data_rdy`, `ovr_flag` and `brk_flag` are 0, and the trigger level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low flushes the queue and the sticky flags |
| in_valid | input | 1 | A finished character is presented this cycle |
| in_char | input | 8 | Received character |
| in_par_err | input | 1 | Parity fault for this character |
| in_frm_err | input | 1 | Framing fault for this character |
| in_brk | input | 1 | Break detected with this character |
| rd_req | input | 1 | Pop the oldest entry at this edge |
| rd_word | output | 16 | Oldest entry with status, or 0 when empty |
| cfg_wr | input | 1 | Load the trigger level |
| cfg_level | input | 6 | New trigger level |
| clr_w1c | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 break |
| rx_rdy | output | 1 | Fill level at or above the trigger level |
| data_rdy | output | 1 | At least one character stored |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Sticky break |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue holds 32 characters |

## Verification
The hardest case to reach is the overrun tag on the newest entry. The queue must first be filled to exactly its depth with no reads, then further characters must be offered. The tag only becomes visible 31 reads later, when the marked entry comes to the head. The stimulus fills the queue with distinct characters and sends two more. It then drains every entry against a scoreboard whose last expected word carries the overrun and summary bits, so a mark on the wrong slot, or a stored dropped character, shows up as a mismatch in the drained sequence.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rxq_err_t;

  localparam int unsigned RXQ_WORD_W = 16;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic              mark_ovr,
  input  logic [DATA_W-1:0] in_char,
  input  rxq_pkg::rxq_err_t in_err,
  output logic [DATA_W-1:0] head_char,
  output rxq_pkg::rxq_err_t head_err,
  output logic              head_ovr,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0]  char_mem [DEPTH];
  rxq_pkg::rxq_err_t  err_mem  [DEPTH];
  logic [DEPTH-1:0]   ovr_tag;
  logic [AW-1:0]      wr_ptr, rd_ptr, newest;
  logic [CW-1:0]      cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign newest = (wr_ptr == '0) ? LAST_IDX : wr_ptr - AW'(1);

  always_ff @(posedge clk) begin
    if (push) begin
      char_mem[wr_ptr] <= in_char;
      err_mem[wr_ptr]  <= in_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
      ovr_tag <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
      ovr_tag <= '0;
    end else begin
      if (push) begin
        wr_ptr          <= step(wr_ptr);
        ovr_tag[wr_ptr] <= 1'b0;
      end
      if (mark_ovr) begin
        ovr_tag[newest] <= 1'b1;
      end
      if (pop) begin
        rd_ptr <= step(rd_ptr);
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_char = char_mem[rd_ptr];
  assign head_err  = err_mem[rd_ptr];
  assign head_ovr  = ovr_tag[rd_ptr];
  assign count     = cnt_q;
  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int unsigned LVL_W     = 6,
  parameter int unsigned CW        = 6,
  parameter int unsigned LVL_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cfg_wr,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [CW-1:0]    count,
  input  logic             brk_set,
  input  logic             ovr_set,
  input  logic [1:0]       clr_w1c,
  output logic             rx_rdy,
  output logic             data_rdy,
  output logic             ovr_flag,
  output logic             brk_flag
);
  logic [LVL_W-1:0] trig_q;
  logic             ovr_q, brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= LVL_W'(LVL_RESET);
    end else if (cfg_wr) begin
      trig_q <= cfg_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else if (flush) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (ovr_set)         ovr_q <= 1'b1;
      else if (clr_w1c[0]) ovr_q <= 1'b0;
      if (brk_set)         brk_q <= 1'b1;
      else if (clr_w1c[1]) brk_q <= 1'b0;
    end
  end

  assign rx_rdy   = (32'(count) >= 32'(trig_q));
  assign data_rdy = (count != '0);
  assign ovr_flag = ovr_q;
  assign brk_flag = brk_q;
endmodule

// File: rtl/rxq_pack.sv
module rxq_pack #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] char_in,
  input  rxq_pkg::rxq_err_t err_in,
  input  logic              ovr_in,
  output logic [rxq_pkg::RXQ_WORD_W-1:0] word
);
  logic [9:0] low;
  logic       summary;

  always_comb begin
    low = '0;
    low[DATA_W-1:0] = char_in;
  end

  assign summary = ovr_in | err_in.frm | err_in.brk | err_in.par;

  assign word = valid ? {1'b1, summary, ovr_in, err_in.frm, err_in.brk, err_in.par, low}
                      : '0;
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_char,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              in_brk,
  input  logic              rd_req,
  output logic [15:0]       rd_word,
  input  logic              cfg_wr,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [1:0]        clr_w1c,
  output logic              rx_rdy,
  output logic              data_rdy,
  output logic              ovr_flag,
  output logic              brk_flag,
  output logic              fifo_empty,
  output logic              fifo_full
);
  logic              flush, push, pop, drop, brk_seen;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] head_char;
  rxq_pkg::rxq_err_t head_err, arr_err;
  logic              head_ovr;

  assign flush    = !rx_enable;
  assign push     = rx_enable & in_valid & !fifo_full;
  assign drop     = rx_enable & in_valid & fifo_full;
  assign pop      = rx_enable & rd_req & !fifo_empty;
  assign brk_seen = rx_enable & in_valid & in_brk;
  assign arr_err  = '{par: in_par_err, frm: in_frm_err, brk: in_brk};

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .pop       (pop),
    .mark_ovr  (drop),
    .in_char   (in_char),
    .in_err    (arr_err),
    .head_char (head_char),
    .head_err  (head_err),
    .head_ovr  (head_ovr),
    .count     (count),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  rxq_flags #(.LVL_W(LVL_W), .CW(CW), .LVL_RESET(1)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cfg_wr    (cfg_wr),
    .cfg_level (cfg_level),
    .count     (count),
    .brk_set   (brk_seen),
    .ovr_set   (drop),
    .clr_w1c   (clr_w1c),
    .rx_rdy    (rx_rdy),
    .data_rdy  (data_rdy),
    .ovr_flag  (ovr_flag),
    .brk_flag  (brk_flag)
  );

  rxq_pack #(.DATA_W(DATA_W)) u_pack (
    .valid   (!fifo_empty),
    .char_in (head_char),
    .err_in  (head_err),
    .ovr_in  (head_ovr),
    .word    (rd_word)
  );
endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk #(
  parameter int unsigned DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_enable,
  input logic        in_valid,
  input logic        in_brk,
  input logic        rd_req,
  input logic [15:0] rd_word,
  input logic [1:0]  clr_w1c,
  input logic        data_rdy,
  input logic        ovr_flag,
  input logic        brk_flag,
  input logic        fifo_empty,
  input logic        fifo_full
);
  // R1: valid bit follows occupancy
  a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[15] == !fifo_empty);

  // R1: summary bit is the OR of the four fault bits
  a_r1_summary: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[14] == (|rd_word[13:10]));

  // R2: full and empty never together
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  // R4: data ready agrees with occupancy
  a_r4_data_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy == !fifo_empty);

  // R5: break flag stays set without a clear
  a_r5_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && rx_enable && !clr_w1c[1] |=> brk_flag);

  // R6: a character offered to a full queue leaves it full and flags overrun
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && in_valid && rx_enable && !rd_req |=> fifo_full && ovr_flag);

  // R7: empty read without arrival leaves the queue empty
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && rd_req && !in_valid |=> fifo_empty);

  // R9: disable flushes queue and sticky flags
  a_r9_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> fifo_empty && !ovr_flag && !brk_flag);

  // R5: a break arrival sets the flag
  a_r5_brk_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && in_valid && in_brk |=> brk_flag);
endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_enable  (rx_enable),
  .in_valid   (in_valid),
  .in_brk     (in_brk),
  .rd_req     (rd_req),
  .rd_word    (rd_word),
  .clr_w1c    (clr_w1c),
  .data_rdy   (data_rdy),
  .ovr_flag   (ovr_flag),
  .brk_flag   (brk_flag),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full)
);

// File: tb/rxq_tagged_fifo_bench.sv
`timescale 1ns/1ps
module rxq_tagged_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = '0;
  logic        in_par_err = 1'b0, in_frm_err = 1'b0, in_brk = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_word;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_level = '0;
  logic [1:0]  clr_w1c = '0;
  logic        rx_rdy, data_rdy, ovr_flag, brk_flag, fifo_empty, fifo_full;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  rxq_tagged_fifo u_rxq_tagged_fifo (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .in_valid(in_valid),
    .in_char(in_char), .in_par_err(in_par_err), .in_frm_err(in_frm_err),
    .in_brk(in_brk), .rd_req(rd_req), .rd_word(rd_word), .cfg_wr(cfg_wr),
    .cfg_level(cfg_level), .clr_w1c(clr_w1c), .rx_rdy(rx_rdy),
    .data_rdy(data_rdy), .ovr_flag(ovr_flag), .brk_flag(brk_flag),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offer one character and update the scoreboard
  task automatic send(input logic [7:0] c, input logic p, input logic f, input logic b);
    @(negedge clk);
    in_valid = 1'b1; in_char = c; in_par_err = p; in_frm_err = f; in_brk = b;
    @(negedge clk);
    in_valid = 1'b0; in_par_err = 1'b0; in_frm_err = 1'b0; in_brk = 1'b0;
    if (exp_q.size() < 32)
      exp_q.push_back({1'b1, p | f | b, 1'b0, f, b, p, 2'b00, c});
    else
      exp_q[$] = exp_q[$] | 16'h6000;
  endtask

  // monitor: compare the head word, then pop it
  task automatic take(input string req);
    logic [15:0] e;
    @(negedge clk);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
    check(req, rd_word, e);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic set_level(input logic [5:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_level = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk); clr_w1c = m;
    @(negedge clk); clr_w1c = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 empty", 16'(fifo_empty), 16'd1);
    check("R10 flags", {12'd0, rx_rdy, data_rdy, ovr_flag, brk_flag}, 16'd0);
    check("R1 empty word", rd_word, 16'h0000);

    // R4 / R3: one plain character, default trigger level 1
    send(8'hA5, 0, 0, 0);
    check("R4 data_rdy", 16'(data_rdy), 16'd1);
    check("R3 rx_rdy default level", 16'(rx_rdy), 16'd1);
    take("R1 plain char");

    // R1: each fault bit in its own position
    send(8'h11, 1, 0, 0);
    send(8'h22, 0, 1, 0);
    send(8'h33, 0, 0, 1);
    take("R1 parity bit10");
    take("R1 framing bit12");
    take("R1 break bit11");
    check("R5 brk set", 16'(brk_flag), 16'd1);

    // R3: trigger level 4
    set_level(6'd4);
    for (int i = 0; i < 3; i++) send(8'(8'h40 + i), 0, 0, 0);
    check("R3 below level", 16'(rx_rdy), 16'd0);
    check("R4 independent of level", 16'(data_rdy), 16'd1);
    send(8'h43, 0, 0, 0);
    check("R3 at level", 16'(rx_rdy), 16'd1);
    for (int i = 0; i < 4; i++) take("R2 order");
    set_level(6'd1);

    // R2 / R6: fill and overrun
    for (int i = 0; i < 32; i++) send(8'(8'h80 + i), 0, 0, 0);
    check("R2 full", 16'(fifo_full), 16'd1);
    check("R6 no ovr yet", 16'(ovr_flag), 16'd0);
    send(8'hEE, 0, 0, 0);
    send(8'hEF, 0, 0, 0);
    check("R6 ovr flag", 16'(ovr_flag), 16'd1);
    check("R6 still full", 16'(fifo_full), 16'd1);
    for (int i = 0; i < 32; i++) take("R6 drained entry");
    check("R2 empty after drain", 16'(fifo_empty), 16'd1);

    // R7: empty read changes nothing
    take("R7 empty read");
    take("R7 second empty read");
    send(8'h5A, 0, 0, 0);
    take("R7 next stored char");

    // R8: clear overrun only
    clear(2'b01);
    check("R8 ovr cleared", 16'(ovr_flag), 16'd0);
    check("R8 brk kept", 16'(brk_flag), 16'd1);
    clear(2'b10);
    check("R5 brk cleared", 16'(brk_flag), 16'd0);

    // R9: disable flushes and ignores input
    send(8'h01, 0, 0, 1);
    send(8'h02, 0, 0, 0);
    @(negedge clk);
    rx_enable = 1'b0; in_valid = 1'b1; in_char = 8'h77;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 flushed", 16'(fifo_empty), 16'd1);
    check("R9 flags cleared", {14'd0, ovr_flag, brk_flag}, 16'd0);
    check("R9 word zero", rd_word, 16'h0000);
    rx_enable = 1'b1;
    exp_q.delete();
    @(negedge clk);
    check("R9 still empty", 16'(fifo_empty), 16'd1);
    check("R9 level kept", 16'(rx_rdy), 16'd0);
    send(8'h99, 0, 0, 0);
    take("R9 after re-enable");

    finish_run();
  end
endmodule